// File: doc/BRIEF.md
# Interrupt Enable, Pending and Active State Tracker

This block keeps per-line state for a parameterised set of external interrupt lines (32 by default). Every line owns an enable flag, a pending flag, an active flag and a priority level. Software programs the enable and pending flags through paired set and clear word addresses, so any single line can be changed without a read-modify-write of its neighbours. Priorities sit in byte lanes of a small block of words, and the active flags can be read back through the same register bus.

Incoming request lines are latched as pending whether or not the line is enabled, and they stay latched until a handler takes them or software clears them. A combinational selector reports the most urgent line that is both pending and enabled. A core model drives an entry strobe when it accepts the selected line and a return strobe, tagged with a line number, when that handler finishes. Entry marks the line active and removes its pending flag at the same edge. A handler that has been preempted keeps its active flag until its own return arrives.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every enable, pending and active flag and every priority level is zero, and `sel_valid` is low.
- R2: A write to word 0 sets, and a write to word 1 clears, each enable flag whose data bit is 1. Data bits at 0 leave their flags unchanged. A read of either word returns the enable flags, with line n in bit n.
- R3: Words 2 (set) and 3 (clear) act on the pending flags by the same rules. A read of either word returns the pending flags.
- R4: A high `irq_req[n]` at a clock edge sets pending flag n whatever the enable state. A request keeps its flag through later edges until the flag is cleared.
- R5: Word 8+k holds the priorities of lines 4k to 4k+3, with line 4k+j in byte lane j (bits 8j+7 down to 8j). Only the upper PRIO_BITS of each byte are stored, and the lower bits read as zero.
- R6: On every write, `bus_be[j]` gates byte lane j. Data in a lane whose enable is low has no effect.
- R7: Among lines that are both pending and enabled, `sel_id` gives the one with the lowest priority value. A tie goes to the lowest line number. When no such line exists, `sel_valid` is 0 and `sel_id` is 0.
- R8: `entry_strobe` while `sel_valid` is high sets the active flag and clears the pending flag of line `sel_id` at the same edge. A request on that line at that edge keeps it pending.
- R9: An active flag stays set, including while other lines are entered, until `ret_strobe` arrives with `ret_id` equal to that line. That edge clears it.
- R10: Word 4 reads the active flags. Writes to word 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_IRQ | Request lines, sampled each edge |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| entry_strobe | input | 1 | Core accepts the selected line |
| ret_strobe | input | 1 | Core finishes a handler |
| ret_id | input | ID_W | Line whose handler finishes |
| sel_valid | output | 1 | A pending and enabled line exists |
| sel_id | output | ID_W | Selected line number |
| sel_prio | output | PRIO_BITS | Stored priority of the selected line |

## Verification
Assertions check on every cycle that an entry leaves its line active and, without a same-edge request, not pending. They also check that an active flag never drops without a return strobe, that enable and priority state hold when no write targets them, and that a valid selection always names a candidate line. The bench's scenarios show the parts no single-cycle property covers: the lowest-value and lowest-index ordering of the selector, the effect of byte lanes, the dropped low priority bits, the ignored writes to the active word, and a preempted line keeping its active flag through a nested entry and return.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    localparam int unsigned WORD_EN_SET   = 0;
    localparam int unsigned WORD_EN_CLR   = 1;
    localparam int unsigned WORD_PD_SET   = 2;
    localparam int unsigned WORD_PD_CLR   = 3;
    localparam int unsigned WORD_ACTIVE   = 4;
    localparam int unsigned WORD_PRIO_BASE = 8;
    localparam int unsigned LANES         = 4;

    // expand byte-lane enables into a 32-bit data mask
    function automatic logic [31:0] lane_mask(input logic [LANES-1:0] be);
        logic [31:0] m;
        for (int j = 0; j < LANES; j++) m[8*j +: 8] = {8{be[j]}};
        return m;
    endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_trk_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [LANES-1:0]             bus_be,
    input  logic [31:0]                  bus_wdata,
    output logic [NUM_IRQ-1:0]           en_set,
    output logic [NUM_IRQ-1:0]           en_clr,
    output logic [NUM_IRQ-1:0]           pd_set,
    output logic [NUM_IRQ-1:0]           pd_clr,
    output logic [NUM_IRQ-1:0]           prio_we,
    output logic [NUM_IRQ-1:0][7:0]      prio_wbyte
);
    logic        wr;
    logic [31:0] gated;

    always_comb begin
        wr     = bus_sel && bus_wr;
        gated  = bus_wdata & lane_mask(bus_be);
        en_set = '0;
        en_clr = '0;
        pd_set = '0;
        pd_clr = '0;
        if (wr) begin
            unique case (bus_addr)
                ADDR_W'(WORD_EN_SET): en_set = gated[NUM_IRQ-1:0];
                ADDR_W'(WORD_EN_CLR): en_clr = gated[NUM_IRQ-1:0];
                ADDR_W'(WORD_PD_SET): pd_set = gated[NUM_IRQ-1:0];
                ADDR_W'(WORD_PD_CLR): pd_clr = gated[NUM_IRQ-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio_dec
        localparam int unsigned WORD = WORD_PRIO_BASE + i / LANES;
        localparam int unsigned LANE = i % LANES;
        assign prio_we[i]    = wr && (bus_addr == ADDR_W'(WORD)) && bus_be[LANE];
        assign prio_wbyte[i] = bus_wdata[8*LANE +: 8];
    end
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state #(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned ID_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] en_set,
    input  logic [NUM_IRQ-1:0] en_clr,
    input  logic [NUM_IRQ-1:0] pd_set,
    input  logic [NUM_IRQ-1:0] pd_clr,
    input  logic               entry_vld,
    input  logic [ID_W-1:0]    entry_id,
    input  logic               ret_vld,
    input  logic [ID_W-1:0]    ret_id,
    output logic [NUM_IRQ-1:0] en_o,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] act_o
);
    localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

    typedef struct packed {
        logic [NUM_IRQ-1:0] en;
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] act;
    } line_st_t;

    line_st_t st_d, st_q;
    logic [NUM_IRQ-1:0] entry_mask, ret_mask;

    always_comb begin
        entry_mask = entry_vld ? (ONE << entry_id) : '0;
        ret_mask   = ret_vld   ? (ONE << ret_id)   : '0;
        st_d       = st_q;
        st_d.en    = (st_q.en | en_set) & ~en_clr;
        // a request at the entry edge wins over the entry clear
        st_d.pend  = (st_q.pend & ~pd_clr & ~entry_mask) | pd_set | irq_req;
        // an entry wins over a return to the same line
        st_d.act   = (st_q.act & ~ret_mask) | entry_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;

    // R8
    entry_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_vld |=> act_o[$past(entry_id)]);

    // R8
    entry_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && !irq_req[entry_id] && !pd_set[entry_id]) |=> !pend_o[$past(entry_id)]);

    // R9
    active_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_vld |=> (($past(act_o) & ~act_o) == '0));

    // R2
    enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set == '0 && en_clr == '0) |=> $stable(en_o));

    // R4
    request_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |=> ((pend_o & $past(irq_req)) == $past(irq_req)));
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
    parameter int unsigned NUM_IRQ   = 32,
    parameter int unsigned PRIO_BITS = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_IRQ-1:0]                  prio_we,
    input  logic [NUM_IRQ-1:0][7:0]             prio_wbyte,
    output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]   prio_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0][PRIO_BITS-1:0] lvl;
    } prio_st_t;

    prio_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // keep only the upper bits of the written byte
            if (prio_we[i]) st_d.lvl[i] = prio_wbyte[i][7 -: PRIO_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prio_o = st_q.lvl;

    // R5
    prio_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_we == '0) |=> $stable(prio_o));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
    parameter int unsigned NUM_IRQ   = 32,
    parameter int unsigned PRIO_BITS = 3,
    parameter int unsigned ID_W      = 5
) (
    input  logic [NUM_IRQ-1:0]                cand,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
    output logic                              sel_valid,
    output logic [ID_W-1:0]                   sel_id,
    output logic [PRIO_BITS-1:0]              sel_prio
);
    always_comb begin
        sel_valid = 1'b0;
        sel_id    = '0;
        sel_prio  = '0;
        // ascending scan; strict compare keeps the lower index on a tie
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!sel_valid || (prio[i] < sel_prio))) begin
                sel_valid = 1'b1;
                sel_id    = ID_W'(i);
                sel_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
    import irq_trk_pkg::*;
#(
    parameter int unsigned NUM_IRQ   = 32,
    parameter int unsigned PRIO_BITS = 3,
    parameter int unsigned ADDR_W    = 4,
    localparam int unsigned ID_W     = $clog2(NUM_IRQ),
    localparam int unsigned PRIO_WORDS = NUM_IRQ / LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_req,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [LANES-1:0]     bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 entry_strobe,
    input  logic                 ret_strobe,
    input  logic [ID_W-1:0]      ret_id,
    output logic                 sel_valid,
    output logic [ID_W-1:0]      sel_id,
    output logic [PRIO_BITS-1:0] sel_prio
);
    logic [NUM_IRQ-1:0]                en_set, en_clr, pd_set, pd_clr, prio_we;
    logic [NUM_IRQ-1:0][7:0]           prio_wbyte;
    logic [NUM_IRQ-1:0]                en_q, pend_q, act_q, cand;
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;
    logic                              entry_vld;

    irq_bus_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set),
        .pd_clr(pd_clr), .prio_we(prio_we), .prio_wbyte(prio_wbyte)
    );

    assign entry_vld = entry_strobe && sel_valid;

    irq_line_state #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_set(en_set), .en_clr(en_clr),
        .pd_set(pd_set), .pd_clr(pd_clr), .entry_vld(entry_vld), .entry_id(sel_id),
        .ret_vld(ret_strobe), .ret_id(ret_id), .en_o(en_q), .pend_o(pend_q), .act_o(act_q)
    );

    irq_prio_store #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk(clk), .rst_n(rst_n), .prio_we(prio_we), .prio_wbyte(prio_wbyte), .prio_o(prio_q)
    );

    assign cand = en_q & pend_q;

    irq_prio_select #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_sel (
        .cand(cand), .prio(prio_q), .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio)
    );

    // read path
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(WORD_EN_SET), ADDR_W'(WORD_EN_CLR): bus_rdata = 32'(en_q);
            ADDR_W'(WORD_PD_SET), ADDR_W'(WORD_PD_CLR): bus_rdata = 32'(pend_q);
            ADDR_W'(WORD_ACTIVE):                       bus_rdata = 32'(act_q);
            default: begin
                for (int w = 0; w < PRIO_WORDS; w++) begin
                    if (bus_addr == ADDR_W'(WORD_PRIO_BASE + w)) begin
                        for (int j = 0; j < LANES; j++)
                            bus_rdata[8*j +: 8] = 8'(prio_q[LANES*w + j]) << (8 - PRIO_BITS);
                    end
                end
            end
        endcase
    end

    // R7
    sel_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> cand[sel_id]);

    // R7
    no_cand_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (cand == '0 && sel_id == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && pend_q == '0 && act_q == '0) || !rst_n);
endmodule

// File: tb/irq_state_tracker_bench.sv
module irq_state_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ = 32;
    localparam int PRIO_BITS = 3;
    localparam int ID_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NUM_IRQ-1:0] irq_req = '0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic entry_strobe = 1'b0, ret_strobe = 1'b0;
    logic [ID_W-1:0] ret_id = '0, sel_id;
    logic sel_valid;
    logic [PRIO_BITS-1:0] sel_prio;

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;

    typedef struct { bit is_sel; logic [31:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_state_tracker #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_irq_state_tracker (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .entry_strobe(entry_strobe), .ret_strobe(ret_strobe), .ret_id(ret_id),
        .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_sel ? 32'({sel_valid, sel_id}) : bus_rdata;
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_sel = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic exp_sel(input bit v, input int id, input string tag);
        item_t it;
        it.is_sel = 1'b1; it.exp = 32'({v, ID_W'(id)}); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic pulse_req(input logic [NUM_IRQ-1:0] m);
        @(posedge clk); #1; irq_req = m;
        @(posedge clk); #1; irq_req = '0;
    endtask

    task automatic enter();
        @(posedge clk); #1; entry_strobe = 1'b1;
        @(posedge clk); #1; entry_strobe = 1'b0;
    endtask

    task automatic leave(input int id);
        @(posedge clk); #1; ret_strobe = 1'b1; ret_id = ID_W'(id);
        @(posedge clk); #1; ret_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_rd(4'd0, 32'h0, "R1 enable");
        exp_rd(4'd2, 32'h0, "R1 pending");
        exp_rd(4'd4, 32'h0, "R1 active");
        exp_rd(4'd8, 32'h0, "R1 priority");
        exp_sel(0, 0, "R1 selection");

        wr(4'd0, 32'h5, 4'hF);          exp_rd(4'd0, 32'h5, "R2 set");
        wr(4'd0, 32'h100, 4'hF);        exp_rd(4'd0, 32'h105, "R2 set keeps others");
        wr(4'd1, 32'h1, 4'hF);          exp_rd(4'd1, 32'h104, "R2 clear via clear word");
        wr(4'd0, 32'h0, 4'hF);          exp_rd(4'd0, 32'h104, "R2 zero write");
        wr(4'd0, 32'hFFFF_FFFF, 4'b0010); exp_rd(4'd0, 32'hFF04, "R6 lane gate enable");

        pulse_req(32'h408);             exp_rd(4'd2, 32'h408, "R4 request latched");
        exp_sel(1, 10, "R4 disabled line not chosen");

        wr(4'd10, 32'h0060_0000, 4'b0100); exp_rd(4'd10, 32'h0060_0000, "R5 priority lane");
        wr(4'd11, 32'hFFFF_FFFF, 4'b0001); exp_rd(4'd11, 32'h0000_00E0, "R5 R6 upper bits only");

        wr(4'd2, 32'h200, 4'hF);        exp_rd(4'd2, 32'h608, "R3 set pending");
        exp_sel(1, 9, "R7 lower value wins");
        wr(4'd2, 32'h100, 4'hF);        exp_sel(1, 8, "R7 tie lowest index");

        enter();
        exp_rd(4'd4, 32'h100, "R8 active set");
        exp_rd(4'd2, 32'h608, "R8 pending cleared");
        exp_sel(1, 9, "R8 next selection");
        enter();
        exp_rd(4'd4, 32'h300, "R9 preempted stays active");
        exp_rd(4'd2, 32'h408, "R8 second entry");
        exp_sel(1, 10, "R7 after entries");

        wr(4'd4, 32'hFFFF_FFFF, 4'hF);  exp_rd(4'd4, 32'h300, "R10 write ignored");
        leave(9);                       exp_rd(4'd4, 32'h100, "R9 return inner");
        leave(8);                       exp_rd(4'd4, 32'h0, "R9 return outer");

        wr(4'd3, 32'h400, 4'hF);        exp_rd(4'd2, 32'h8, "R3 clear pending");
        exp_sel(0, 0, "R7 no candidate");
        wr(4'd0, 32'h8, 4'hF);          exp_sel(1, 3, "R4 held while disabled");

        wr(4'd8, 32'hE000_0000, 4'b1000);
        wr(4'd2, 32'h1000, 4'hF);       exp_sel(1, 3, "R7 equal value tie");
        wr(4'd2, 32'h2000, 4'hF);       exp_sel(1, 13, "R7 value beats index");
        wr(4'd3, 32'h0, 4'hF);          exp_rd(4'd3, 32'h3008, "R3 zero clear");
        wr(4'd1, 32'hFFFF_FFFF, 4'b0011); exp_rd(4'd1, 32'h0, "R2 R6 lane clear");
        exp_sel(0, 0, "R7 all disabled");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule